// File: doc/BRIEF.md
# Inbound DMA Address Translator

This block turns an address arriving from a downstream bus port into a host-side system address. Each request is sorted into one of five address windows. Two windows are direct: a 64-bit direct window and a 32-bit direct window that uses a per-port base register. Three windows are page-mapped: a 32-bit window of 256 KB pages, a 40-bit window of 64 MB pages, and a 40-bit window of 16 GB super pages. Each window then gets its own translation.

The page-mapped windows look up translation entries. The 32-bit pages and the super pages share one table, with super pages using the low entries. The 64 MB pages have a table of their own. An entry counts only when its top bit is set. Its remaining bits give a page-aligned system address, which is ORed with the in-page offset of the request.

A write port loads the two per-port direct bases and the entries of both tables. Each request produces one registered response, one cycle later. The response carries the system address, a barrier attribute, an MSI flag and an error flag. The design is a datapath with no sequencing states: the window class (NONE, D64, D32, M32, M40, M40S) plays the part that a state would.

Top module: `dma_xlat`

## Requirements
- R1: While `rst_n` is low, and in any cycle after a cycle with `req_valid` low, `resp_valid` is 0. All tables and direct bases reset to zero, which marks them invalid or unprogrammed.
- R2: `resp_valid` is high exactly one cycle after `req_valid`. For an address with bit 63 set and bits 60:54 zero (D64), `resp_addr` is address bits 53:0 with the upper bits zero. `resp_barrier` is address bit 62 and `resp_msi` is address bit 61.
- R3: An erroring response has `resp_err`=1 with `resp_addr`, `resp_barrier` and `resp_msi` all 0. A D64 address with any of bits 60:54 set is an error.
- R4: Addresses 0x8000_0000 to 0xFFFF_FFFF (D32) give the direct base of port `req_port` ORed with address bits 29:0, and `resp_barrier` = address bit 30. Writing a direct base (`wr_target`=0, `wr_index`=port) keeps data bits 63:30 and clears bits 29:0.
- R5: A D32 request on a port whose direct base is zero is an error.
- R6: Addresses 0x0 to 0x7FFF_FFFF (M32) report bit 30 as the barrier and then ignore it. Index bits 29:18 select a shared-table entry (`wr_target`=1), and address bits 17:0 are the offset within the page. The entry's bits 62:18 give the page base.
- R7: Addresses 0x40_0000_0000 to 0x7F_FFFF_FFFF (M40) use the large table (`wr_target`=2). The index is address bits 37:26, the offset is bits 25:0, and the page base is entry bits 62:26. `resp_barrier` is 0.
- R8: Addresses 0x80_0000_0000 to 0xFF_FFFF_FFFF (M40S) use shared-table entry address bits 38:34. The offset is bits 33:0, the page base is entry bits 62:34, and `resp_barrier` is 0.
- R9: A page-mapped request is an error if its entry has bit 63 clear, or if its index is at or beyond the table depth.
- R10: Addresses in no window are errors. These are addresses with bit 63 clear and bits 62:40 nonzero, and addresses from 0x1_0000_0000 to 0x3F_FFFF_FFFF.
- R11: A write changes state at the clock edge where it is sampled. A request sampled at that same edge sees the old contents, and a request sampled at the next edge sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 64 | Inbound bus address |
| req_port | input | 1 | Downstream port of the request |
| wr_en | input | 1 | Register write strobe |
| wr_target | input | 2 | 0 direct base, 1 shared table, 2 large table, 3 none |
| wr_index | input | 12 | Port number or table entry index |
| wr_data | input | 64 | Write data |
| resp_valid | output | 1 | Response present |
| resp_addr | output | 64 | Translated system address |
| resp_barrier | output | 1 | Barrier attribute |
| resp_msi | output | 1 | MSI transaction flag |
| resp_err | output | 1 | Translation failed |

## Verification
The hardest case to reach from the ports is a write and a lookup of the same entry at the same clock edge, because the ordering decides which contents the lookup sees. The bench issues a request and a write to that entry in the same cycle and expects the old, invalid result. It then repeats the request and expects the new translation. A second awkward case is the shared table serving two windows at once. The bench fills low entries that the M32 and M40S windows both reach, and checks each window with its own page size.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [2:0] {
        WIN_NONE, WIN_D64, WIN_D32, WIN_M32, WIN_M40, WIN_M40S
    } win_e;

    typedef enum logic [1:0] {
        TGT_DIRMAP = 2'd0,
        TGT_SHARED = 2'd1,
        TGT_LARGE  = 2'd2,
        TGT_NONE   = 2'd3
    } wr_tgt_e;

    // page sizes as bit shifts
    localparam int unsigned SH_SMALL = 18;   // 256 KB
    localparam int unsigned SH_LARGE = 26;   // 64 MB
    localparam int unsigned SH_SUPER = 34;   // 16 GB
    localparam int unsigned SH_DIR   = 30;   // direct base granularity
    localparam int unsigned IDX_W    = 12;
endpackage

// File: rtl/xlat_classify.sv
module xlat_classify
    import xlat_pkg::*;
(
    input  logic [63:0]      addr,
    output win_e             win,
    output logic [IDX_W-1:0] idx,
    output logic [63:0]      offs,
    output logic             bar,
    output logic             msi
);
    always_comb begin
        win  = WIN_NONE;
        idx  = '0;
        offs = '0;
        bar  = 1'b0;
        msi  = 1'b0;
        if (addr[63]) begin
            if (addr[60:54] == 7'd0) begin
                win  = WIN_D64;
                offs = {10'd0, addr[53:0]};
                bar  = addr[62];
                msi  = addr[61];
            end
        end else if (addr[62:32] == '0 && addr[31]) begin
            win  = WIN_D32;
            bar  = addr[30];
            offs = {34'd0, addr[29:0]};
        end else if (addr[62:31] == '0) begin
            win  = WIN_M32;
            bar  = addr[30];
            idx  = addr[29:18];
            offs = {46'd0, addr[17:0]};
        end else if (addr[62:40] == '0 && addr[39:38] == 2'b01) begin
            win  = WIN_M40;
            idx  = addr[37:26];
            offs = {38'd0, addr[25:0]};
        end else if (addr[62:40] == '0 && addr[39]) begin
            win  = WIN_M40S;
            idx  = {7'd0, addr[38:34]};
            offs = {30'd0, addr[33:0]};
        end
    end
endmodule

// File: rtl/xlat_entry_table.sv
module xlat_entry_table #(
    parameter  int unsigned DEPTH = 64,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [63:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [63:0]   rdata
);
    logic [63:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dma_xlat.sv
module dma_xlat
    import xlat_pkg::*;
#(
    parameter  int unsigned NUM_PORTS = 2,
    parameter  int unsigned SH_DEPTH  = 128,
    parameter  int unsigned LG_DEPTH  = 64,
    localparam int unsigned PORT_W    = $clog2(NUM_PORTS),
    localparam int unsigned SH_AW     = $clog2(SH_DEPTH),
    localparam int unsigned LG_AW     = $clog2(LG_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    input  logic [PORT_W-1:0] req_port,
    input  logic              wr_en,
    input  logic [1:0]        wr_target,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [63:0]       wr_data,
    output logic              resp_valid,
    output logic [63:0]       resp_addr,
    output logic              resp_barrier,
    output logic              resp_msi,
    output logic              resp_err
);
    localparam logic [63:0] ENT_BODY = {1'b0, {63{1'b1}}};
    localparam logic [63:0] MSK_SMALL = (64'd1 << SH_SMALL) - 64'd1;
    localparam logic [63:0] MSK_LARGE = (64'd1 << SH_LARGE) - 64'd1;
    localparam logic [63:0] MSK_SUPER = (64'd1 << SH_SUPER) - 64'd1;

    wr_tgt_e tgt;
    assign tgt = wr_tgt_e'(wr_target);

    // ---------------- direct bases ----------------
    logic [63:0] dir_q [NUM_PORTS];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PORTS; p++) dir_q[p] <= '0;
        end else if (wr_en && tgt == TGT_DIRMAP) begin
            for (int p = 0; p < NUM_PORTS; p++)
                if (32'(wr_index) == p)
                    dir_q[p] <= {wr_data[63:SH_DIR], {SH_DIR{1'b0}}};
        end
    end

    // ---------------- classification ----------------
    win_e             win;
    logic [IDX_W-1:0] idx;
    logic [63:0]      offs;
    logic             cls_bar, cls_msi;

    xlat_classify u_cls (
        .addr(req_addr), .win(win), .idx(idx),
        .offs(offs), .bar(cls_bar), .msi(cls_msi)
    );

    // ---------------- translation tables ----------------
    logic        sh_we, lg_we;
    logic [63:0] sh_rd, lg_rd;

    assign sh_we = wr_en && tgt == TGT_SHARED && 32'(wr_index) < SH_DEPTH;
    assign lg_we = wr_en && tgt == TGT_LARGE  && 32'(wr_index) < LG_DEPTH;

    xlat_entry_table #(.DEPTH(SH_DEPTH)) u_sh_tbl (
        .clk(clk), .rst_n(rst_n), .we(sh_we),
        .waddr(wr_index[SH_AW-1:0]), .wdata(wr_data),
        .raddr(idx[SH_AW-1:0]), .rdata(sh_rd)
    );

    xlat_entry_table #(.DEPTH(LG_DEPTH)) u_lg_tbl (
        .clk(clk), .rst_n(rst_n), .we(lg_we),
        .waddr(wr_index[LG_AW-1:0]), .wdata(wr_data),
        .raddr(idx[LG_AW-1:0]), .rdata(lg_rd)
    );

    logic sh_hit, lg_hit;
    assign sh_hit = 32'(idx) < SH_DEPTH && sh_rd[63];
    assign lg_hit = 32'(idx) < LG_DEPTH && lg_rd[63];

    // ---------------- per-window result ----------------
    logic [63:0] nx_addr;
    logic        nx_bar, nx_msi, nx_err;

    always_comb begin
        nx_addr = '0;
        nx_bar  = 1'b0;
        nx_msi  = 1'b0;
        nx_err  = 1'b0;
        unique case (win)
            WIN_D64: begin
                nx_addr = offs;
                nx_bar  = cls_bar;
                nx_msi  = cls_msi;
            end
            WIN_D32: begin
                if (32'(req_port) >= NUM_PORTS || dir_q[req_port] == '0) nx_err = 1'b1;
                else begin
                    nx_addr = dir_q[req_port] | offs;
                    nx_bar  = cls_bar;
                end
            end
            WIN_M32: begin
                if (!sh_hit) nx_err = 1'b1;
                else begin
                    nx_addr = (sh_rd & ENT_BODY & ~MSK_SMALL) | offs;
                    nx_bar  = cls_bar;
                end
            end
            WIN_M40: begin
                if (!lg_hit) nx_err = 1'b1;
                else nx_addr = (lg_rd & ENT_BODY & ~MSK_LARGE) | offs;
            end
            WIN_M40S: begin
                if (!sh_hit) nx_err = 1'b1;
                else nx_addr = (sh_rd & ENT_BODY & ~MSK_SUPER) | offs;
            end
            WIN_NONE: nx_err = 1'b1;
            default:  nx_err = 1'b1;
        endcase
    end

    // ---------------- response register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid   <= 1'b0;
            resp_addr    <= '0;
            resp_barrier <= 1'b0;
            resp_msi     <= 1'b0;
            resp_err     <= 1'b0;
        end else begin
            resp_valid   <= req_valid;
            resp_addr    <= req_valid ? nx_addr : '0;
            resp_barrier <= req_valid && nx_bar;
            resp_msi     <= req_valid && nx_msi;
            resp_err     <= req_valid && nx_err;
        end
    end
endmodule

// File: rtl/dma_xlat_checker.sv
module dma_xlat_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [63:0] req_addr,
    input logic        resp_valid,
    input logic [63:0] resp_addr,
    input logic        resp_barrier,
    input logic        resp_msi,
    input logic        resp_err
);
    // R1, R2: one response per request, one cycle later
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    // R3: error responses carry nothing else
    a_r3_err_clean: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> (resp_addr == 64'd0 && !resp_barrier && !resp_msi));
    // R2: MSI only from the 64-bit direct window
    a_r2_msi_d64: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr[63]) |=> !resp_msi);
    // R7, R8: no barrier in 40-bit windows
    a_r7_no_bar40: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr[63] && req_addr[62:40] == 23'd0
         && req_addr[39:38] != 2'b00) |=> !resp_barrier);
    // R10: unmatched high addresses error
    a_r10_nowin: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr[63] && req_addr[62:40] != 23'd0) |=> resp_err);
    // R3: reserved bits in 64-bit direct
    a_r3_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[63] && req_addr[60:54] != 7'd0) |=> resp_err);
endmodule

bind dma_xlat dma_xlat_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_addr(resp_addr),
    .resp_barrier(resp_barrier), .resp_msi(resp_msi), .resp_err(resp_err)
);

// File: tb/dma_xlat_tb.sv
module dma_xlat_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [0:0]  req_port = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_target = 2'd3;
    logic [11:0] wr_index = '0;
    logic [63:0] wr_data = '0;
    logic        resp_valid, resp_barrier, resp_msi, resp_err;
    logic [63:0] resp_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [63:0] a;
        logic        b, m, e;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;   // 250 MHz

    dma_xlat u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_port(req_port), .wr_en(wr_en), .wr_target(wr_target),
        .wr_index(wr_index), .wr_data(wr_data), .resp_valid(resp_valid),
        .resp_addr(resp_addr), .resp_barrier(resp_barrier),
        .resp_msi(resp_msi), .resp_err(resp_err)
    );

    // monitor
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            n_chk++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R1: response with no request, got valid=1 expected valid=0");
            end else begin
                exp_t x;
                x = q.pop_front();
                if (resp_addr !== x.a || resp_barrier !== x.b ||
                    resp_msi !== x.m || resp_err !== x.e) begin
                    n_bad++;
                    $display("FAIL %s: got addr=%h bar=%b msi=%b err=%b expected addr=%h bar=%b msi=%b err=%b",
                             x.tag, resp_addr, resp_barrier, resp_msi, resp_err,
                             x.a, x.b, x.m, x.e);
                end
            end
        end
    end

    task automatic send(input logic [63:0] a, input logic p,
                        input logic [63:0] ea, input logic eb,
                        input logic em, input logic ee, input string tag);
        exp_t x;
        @(negedge clk);
        wr_en = 1'b0;
        req_valid = 1'b1; req_addr = a; req_port = p;
        x.a = ea; x.b = eb; x.m = em; x.e = ee; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic wr(input logic [1:0] t, input logic [11:0] i, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        wr_en = 1'b1; wr_target = t; wr_index = i; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (resp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got resp_valid=%b expected 0 in reset", resp_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (resp_valid !== 1'b0 || resp_err !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got valid=%b err=%b expected 0 0 after reset", resp_valid, resp_err);
        end

        // R2 64-bit direct
        send(64'hC000_0123_4567_89AB, 0, 64'h0000_0123_4567_89AB, 1, 0, 0, "R2 d64 barrier");
        send(64'hA000_0000_0000_1000, 1, 64'h0000_0000_0000_1000, 0, 1, 0, "R2 d64 msi");
        // R3 reserved bits
        send(64'h8040_0000_0000_0000, 0, 64'h0, 0, 0, 1, "R3 d64 reserved");
        // R5 unprogrammed direct base
        send(64'h0000_0000_8000_0100, 0, 64'h0, 0, 0, 1, "R5 d32 unprogrammed");

        // R4 direct bases
        wr(2'd0, 12'd0, 64'h0000_0012_7FFF_FFFF);
        wr(2'd0, 12'd1, 64'h0000_0056_C000_0000);
        send(64'h0000_0000_C123_4567, 0, 64'h0000_0012_4123_4567, 1, 0, 0, "R4 d32 port0 barrier");
        send(64'h0000_0000_8000_0010, 1, 64'h0000_0056_C000_0010, 0, 0, 0, "R4 d32 port1");
        send(64'h0000_0000_8000_0010, 0, 64'h0000_0012_4000_0010, 0, 0, 0, "R4 d32 port0");

        // R6 shared table small pages
        wr(2'd1, 12'd5, 64'h8000_0000_ABCC_1234);
        send(64'h0000_0000_4014_1ABC, 0, 64'h0000_0000_ABCC_1ABC, 1, 0, 0, "R6 m32 barrier");
        send(64'h0000_0000_0014_0004, 1, 64'h0000_0000_ABCC_0004, 0, 0, 0, "R6 m32 plain");
        // R9 invalid entry, out-of-depth index
        send(64'h0000_0000_0018_0000, 0, 64'h0, 0, 0, 1, "R9 m32 invalid entry");
        send(64'h0000_0000_0320_0000, 0, 64'h0, 0, 0, 1, "R9 m32 beyond depth");

        // R7 large table
        wr(2'd2, 12'd3, 64'h8000_0012_3400_0000);
        send(64'h0000_0040_0C12_3456, 0, 64'h0000_0012_3412_3456, 0, 0, 0, "R7 m40");
        send(64'h0000_0041_9000_0000, 0, 64'h0, 0, 0, 1, "R9 m40 beyond depth");

        // R8 super pages in shared table
        wr(2'd1, 12'd2, 64'h8000_0300_0000_0000);
        send(64'h0000_0089_2345_6789, 1, 64'h0000_0301_2345_6789, 0, 0, 0, "R8 m40s");
        send(64'h0000_0080_0000_0040, 0, 64'h0, 0, 0, 1, "R9 m40s invalid entry");

        // R10 unmatched
        send(64'h0000_0001_0000_0000, 0, 64'h0, 0, 0, 1, "R10 gap below 40-bit");
        send(64'h0000_0100_0000_0000, 0, 64'h0, 0, 0, 1, "R10 above 40-bit");

        // R11 write and lookup at the same edge
        @(negedge clk);
        begin
            exp_t x;
            req_valid = 1'b1; req_addr = 64'h0000_0000_0018_0000; req_port = 0;
            wr_en = 1'b1; wr_target = 2'd1; wr_index = 12'd6;
            wr_data = 64'h8000_0000_0008_0000;
            x.a = 64'h0; x.b = 0; x.m = 0; x.e = 1; x.tag = "R11 same-edge old";
            q.push_back(x);
        end
        send(64'h0000_0000_0018_0000, 0, 64'h0000_0000_0008_0000, 0, 0, 0, "R11 next-edge new");

        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        n_chk++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: got %0d pending expected 0 pending responses", q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule